// File: doc/BRIEF.md
# Parallel Display Bus Controller

This block runs one transfer at a time on a parallel display bus. Two signalling styles are available. The first has separate active-low write and read strobes. The second has an enable pulse and a direction line. Three requests can start a transfer:

- A command-port write sends a 16-bit word. Bit 16 of that word decides whether it goes out as a command or as a parameter.
- A streamed data beat is taken through a valid/ready handshake and goes out as display data.
- A read request samples the bus into a read data register.

Chip select is set by a separate write and is held until it is written again. Each transfer is split into two phases, and both are timed in divided clock ticks. Writes use a 3-bit divider code and programmable lengths for the first and second phase. Reads use a 4-bit divider code and two ticks per phase. The bus pads sit outside the block. The data bus therefore leaves the block as separate output, input and output-enable signals.

Top module: `pbus_ctrl`

## Requirements
- R1: With `cfg_mode`=0, `bus_wr` is low only during the first phase of a write and `bus_rd` is low only during the first phase of a read; both are high otherwise, including after reset.
- R2: With `cfg_mode`=1, `bus_wr` acts as direction (0 for the whole of a write transfer, 1 otherwise) and `bus_rd` acts as enable, high only during the second phase; the transfer ends as enable falls.
- R3: With `cfg_wide`=0, only bits 7:0 are used: `bus_dout` carries the low byte with bits 15:8 zero, and a read stores bits 7:0 of `bus_din` zero-extended.
- R4: Write divider code `cfg_wdiv` 0,1,2,3,4,5 gives tick lengths of 1,2,3,4,6,8 clocks; codes 6 and 7 give 8.
- R5: Read divider code `cfg_rdiv` 0..8 gives tick lengths of 1,2,3,4,6,8,16,32,64 clocks; codes 9..15 give 64. A read lasts 4 ticks, 2 in each phase.
- R6: A write's first phase lasts `cfg_wlo`+1 ticks and its second phase `cfg_whi`+1 ticks.
- R7: A command-port write with bit 16 = 0 is sent as a command, and with bit 16 = 1 as data. Streamed beats and reads use the data state. The DC state is held between transfers.
- R8: `bus_cs` and `bus_dc` are high in their active state when their polarity bit is 1 and low when it is 0. For DC, the active state means command.
- R9: A `cs_wr` pulse with `cs_val`=0 asserts chip select and with `cs_val`=1 releases it. Chip select changes at no other time and is released after reset.
- R10: A read captures the bus at the last clock of the first phase (`cfg_mode`=0) or of the second phase (`cfg_mode`=1). `rd_data` changes at no other time.
- R11: `busy` is high for exactly the clocks of a transfer. Priority is command write over read request over streamed data. `data_ready` is high only when idle with neither other request present. Requests made while busy are dropped.
- R12: `bus_oe` is high exactly during write transfers, and `bus_dout` holds its value for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 1 | 0: separate strobes, 1: enable plus direction |
| cfg_wide | input | 1 | 0: 8-bit bus, 1: 16-bit bus |
| cfg_cs_pol | input | 1 | Chip select active level |
| cfg_dc_pol | input | 1 | DC level that means command |
| cfg_wdiv | input | 3 | Write divider code |
| cfg_rdiv | input | 4 | Read divider code |
| cfg_wlo | input | 3 | Write first-phase length minus one, in ticks |
| cfg_whi | input | 3 | Write second-phase length minus one, in ticks |
| cmd_wr | input | 1 | Command-port write strobe |
| cmd_word | input | 17 | Word [15:0], bit 16 selects parameter |
| rd_req | input | 1 | Start one read |
| data_valid | input | 1 | Streamed beat present |
| data_ready | output | 1 | Streamed beat accepted this clock |
| data_in | input | 16 | Streamed beat |
| cs_wr | input | 1 | Chip select register write |
| cs_val | input | 1 | 0 asserts, 1 releases |
| busy | output | 1 | Transfer in progress |
| rd_data | output | 16 | Last value read |
| bus_cs | output | 1 | Chip select pin |
| bus_dc | output | 1 | Data/command pin |
| bus_wr | output | 1 | Write strobe or direction |
| bus_rd | output | 1 | Read strobe or enable |
| bus_oe | output | 1 | Bus output enable for the pads |
| bus_dout | output | 16 | Bus value driven |
| bus_din | input | 16 | Bus value sampled |

## Verification
Every divider code is swept, including the codes that saturate. In each case the length of `busy` is measured, which separates each ratio and the saturation from its neighbours. Writes with unequal first and second phases, and reads with a new bus value each time, are run in both signalling styles and at both widths. This shows whether the strobe shapes, the capture points and the byte masking follow the mode bits. Requests are made together and in the middle of a transfer, and chip select and DC are checked under both polarities. These cases test the priority order, the dropping of requests while busy, and the pin inversions.

// File: rtl/pbus_ctrl.sv
module pbus_ctrl #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode,
  input  logic          cfg_wide,
  input  logic          cfg_cs_pol,
  input  logic          cfg_dc_pol,
  input  logic [2:0]    cfg_wdiv,
  input  logic [3:0]    cfg_rdiv,
  input  logic [2:0]    cfg_wlo,
  input  logic [2:0]    cfg_whi,
  input  logic          cmd_wr,
  input  logic [DW:0]   cmd_word,
  input  logic          rd_req,
  input  logic          data_valid,
  output logic          data_ready,
  input  logic [DW-1:0] data_in,
  input  logic          cs_wr,
  input  logic          cs_val,
  output logic          busy,
  output logic [DW-1:0] rd_data,
  output logic          bus_cs,
  output logic          bus_dc,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic          bus_oe,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din
);
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {IDLE, PH_A, PH_B} st_t;

  st_t           st;
  logic          rd_op, is_cmd, cs_act;
  logic [DW-1:0] dreg;
  logic [6:0]    ratio, divcnt;
  logic [3:0]    len_a, len_b, phcnt;

  function automatic logic [6:0] wr_ratio(input logic [2:0] c);
    case (c)
      3'd0: return 7'd1;
      3'd1: return 7'd2;
      3'd2: return 7'd3;
      3'd3: return 7'd4;
      3'd4: return 7'd6;
      default: return 7'd8;
    endcase
  endfunction

  function automatic logic [6:0] rd_ratio(input logic [3:0] c);
    case (c)
      4'd0: return 7'd1;
      4'd1: return 7'd2;
      4'd2: return 7'd3;
      4'd3: return 7'd4;
      4'd4: return 7'd6;
      4'd5: return 7'd8;
      4'd6: return 7'd16;
      4'd7: return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

  wire start  = cmd_wr | rd_req | data_valid;
  wire rd_sel = !cmd_wr && rd_req;
  wire tick   = divcnt == ratio - 7'd1;
  wire ph_end = tick && (phcnt == ((st == PH_A) ? len_a : len_b) - 4'd1);
  wire cap    = rd_op && ph_end && (cfg_mode ? (st == PH_B) : (st == PH_A));
  wire wr_dir = busy && !rd_op;

  assign busy       = st != IDLE;
  assign data_ready = !busy && !cmd_wr && !rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      rd_op  <= 1'b0;
      is_cmd <= 1'b0;
      cs_act <= 1'b0;
      dreg   <= '0;
      ratio  <= 7'd1;
      divcnt <= '0;
      len_a  <= 4'd1;
      len_b  <= 4'd1;
      phcnt  <= '0;
      rd_data <= '0;
    end else begin
      if (cs_wr) cs_act <= !cs_val;
      if (cap) rd_data <= cfg_wide ? bus_din : {{HW{1'b0}}, bus_din[HW-1:0]};
      if (st == IDLE) begin
        divcnt <= '0;
        phcnt  <= '0;
        if (start) begin
          st     <= PH_A;
          rd_op  <= rd_sel;
          is_cmd <= cmd_wr && !cmd_word[DW];
          dreg   <= cmd_wr ? cmd_word[DW-1:0] : data_in;
          ratio  <= rd_sel ? rd_ratio(cfg_rdiv) : wr_ratio(cfg_wdiv);
          len_a  <= rd_sel ? 4'd2 : {1'b0, cfg_wlo} + 4'd1;
          len_b  <= rd_sel ? 4'd2 : {1'b0, cfg_whi} + 4'd1;
        end
      end else begin
        divcnt <= tick ? 7'd0 : divcnt + 7'd1;
        if (ph_end) begin
          phcnt <= '0;
          st    <= (st == PH_A) ? PH_B : IDLE;
        end else if (tick) begin
          phcnt <= phcnt + 4'd1;
        end
      end
    end
  end

  assign bus_cs   = ~(cs_act ^ cfg_cs_pol);
  assign bus_dc   = ~(is_cmd ^ cfg_dc_pol);
  assign bus_wr   = cfg_mode ? !wr_dir : !(st == PH_A && !rd_op);
  assign bus_rd   = cfg_mode ? (st == PH_B) : !(st == PH_A && rd_op);
  assign bus_oe   = wr_dir;
  assign bus_dout = cfg_wide ? dreg : {{HW{1'b0}}, dreg[HW-1:0]};

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> (bus_wr || bus_rd)); // R1
  AST_RW_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && $rose(bus_rd)) |-> $stable(bus_wr)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rd_data)); // R10
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_wr |=> (!$stable(cfg_cs_pol) || $stable(bus_cs))); // R9
  AST_DC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(is_cmd)); // R11
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |=> (!bus_oe || !$stable(cfg_wide) || $stable(bus_dout))); // R12
endmodule

// File: tb/tb_pbus_ctrl.sv
module tb_pbus_ctrl;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_mode = 0, cfg_wide = 1, cfg_cs_pol = 0, cfg_dc_pol = 0;
  logic [2:0] cfg_wdiv = 0, cfg_wlo = 0, cfg_whi = 0;
  logic [3:0] cfg_rdiv = 0;
  logic cmd_wr = 0, rd_req = 0, data_valid = 0, cs_wr = 0, cs_val = 1;
  logic [16:0] cmd_word = 0;
  logic [15:0] data_in = 0, bus_din = 0;
  logic data_ready, busy, bus_cs, bus_dc, bus_wr, bus_rd, bus_oe;
  logic [15:0] rd_data, bus_dout;

  pbus_ctrl dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int wratio(input int c);
    case (c) 0: return 1; 1: return 2; 2: return 3; 3: return 4; 4: return 6; default: return 8; endcase
  endfunction
  function automatic int rratio(input int c);
    case (c) 0: return 1; 1: return 2; 2: return 3; 3: return 4; 4: return 6;
      5: return 8; 6: return 16; 7: return 32; default: return 64; endcase
  endfunction

  // behavioural reference model
  bit m_busy, m_rd, m_cmd, m_cs;
  int m_el, m_split, m_total;
  logic [15:0] m_data, m_rdata;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_rd = 0; m_cmd = 0; m_cs = 0; m_rdata = 0; m_data = 0;
    end else begin
      if (cs_wr) m_cs = !cs_val;
      if (m_busy) begin
        if (m_rd && ((!cfg_mode && m_el == m_split - 1) || (cfg_mode && m_el == m_total - 1)))
          m_rdata = cfg_wide ? bus_din : {8'h00, bus_din[7:0]};
        m_el++;
        if (m_el == m_total) m_busy = 0;
      end else if (cmd_wr || (!rd_req && data_valid)) begin
        m_busy = 1; m_el = 0; m_rd = 0;
        m_cmd = cmd_wr ? !cmd_word[16] : 1'b0;
        m_data = cmd_wr ? cmd_word[15:0] : data_in;
        m_split = (int'(cfg_wlo) + 1) * wratio(cfg_wdiv);
        m_total = m_split + (int'(cfg_whi) + 1) * wratio(cfg_wdiv);
      end else if (rd_req) begin
        m_busy = 1; m_el = 0; m_rd = 1; m_cmd = 0;
        m_split = 2 * rratio(cfg_rdiv);
        m_total = 4 * rratio(cfg_rdiv);
      end
    end
    #(CLK_P/4);
    if (rst_n && !done) begin
      bit pa, pb, e_wr, e_rd;
      string st;
      pa = m_busy && m_el < m_split;
      pb = m_busy && !pa;
      st = cfg_mode ? "R2" : "R1";
      e_wr = cfg_mode ? !(m_busy && !m_rd) : !(pa && !m_rd);
      e_rd = cfg_mode ? pb : !(pa && m_rd);
      chk("R11", "busy", busy, m_busy);
      chk("R11", "data_ready", data_ready, !m_busy && !cmd_wr && !rd_req);
      chk(st, "bus_wr", bus_wr, e_wr);
      chk(st, "bus_rd", bus_rd, e_rd);
      chk("R12", "bus_oe", bus_oe, m_busy && !m_rd);
      if (m_busy && !m_rd) chk("R3", "bus_dout", bus_dout, cfg_wide ? m_data : {8'h00, m_data[7:0]});
      chk("R9", "bus_cs", bus_cs, cfg_cs_pol ? m_cs : !m_cs);
      chk("R7", "bus_dc", bus_dc, cfg_dc_pol ? m_cmd : !m_cmd);
      chk("R10", "rd_data", rd_data, m_rdata);
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic set_cs(input logic v);
    @(negedge clk); cs_wr = 1; cs_val = v;
    @(negedge clk); cs_wr = 0;
  endtask

  task automatic measure(input string tag, input int exp, input bit poke);
    int n = 0;
    while (busy) begin
      n++;
      if (poke && n == 2) begin cmd_wr = 1; cmd_word = 17'h0_5555; rd_req = 1; end
      else begin cmd_wr = 0; rd_req = 0; end
      @(negedge clk);
    end
    cmd_wr = 0; rd_req = 0;
    chk(tag, "transfer length", n, exp);
  endtask

  task automatic do_cmd(input logic [16:0] w, input string tag, input int exp, input bit poke);
    @(negedge clk); cmd_wr = 1; cmd_word = w;
    @(negedge clk); cmd_wr = 0;
    measure(tag, exp, poke);
  endtask

  task automatic do_read(input logic [15:0] v, input int exp);
    @(negedge clk); bus_din = v; rd_req = 1;
    @(negedge clk); rd_req = 0;
    measure("R5", exp, 0);
    chk("R10", "rd_data after read", rd_data, cfg_wide ? v : {8'h00, v[7:0]});
  endtask

  task automatic stream(input logic [15:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); data_valid = 1; data_in = base + 16'(i) * 16'h1111;
      while (!data_ready) @(negedge clk);
    end
    @(negedge clk); data_valid = 0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset bus_wr", bus_wr, 1);
    chk("R1", "reset bus_rd", bus_rd, 1);
    chk("R9", "reset cs released (active low)", bus_cs, 1);
    chk("R11", "reset busy", busy, 0);

    // separate strobes, 16-bit
    set_cs(0);
    chk("R9", "cs asserted low", bus_cs, 0);
    do_cmd(17'h0_002A, "R6", 2, 0);
    chk("R7", "command leaves DC low", bus_dc, 0);
    cfg_wdiv = 1; cfg_wlo = 2; cfg_whi = 1;
    do_cmd(17'h1_BEEF, "R6", 10, 0);
    chk("R7", "parameter leaves DC high", bus_dc, 1);

    // write divider sweep
    cfg_wlo = 1; cfg_whi = 0;
    for (int c = 0; c < 8; c++) begin
      cfg_wdiv = 3'(c);
      do_cmd(17'h1_0000 | 17'(c * 16'h0101), "R4", 3 * wratio(c), 0);
    end

    // read divider sweep
    for (int c = 0; c < 16; c++) begin
      cfg_rdiv = 4'(c);
      do_read(16'hA5C3 ^ 16'(c * 16'h1357), 4 * rratio(c));
    end

    // 8-bit width
    cfg_wide = 0; cfg_wdiv = 2; cfg_wlo = 0; cfg_whi = 2; cfg_rdiv = 1;
    do_cmd(17'h0_ABCD, "R3", 12, 0);
    do_read(16'h7E81, 8);
    stream(16'h1234, 4);

    // enable/direction style
    cfg_mode = 1; cfg_wide = 1; cfg_wdiv = 0; cfg_wlo = 1; cfg_whi = 2;
    do_cmd(17'h1_C0DE, "R6", 5, 0);
    do_read(16'h3C96, 8);
    cfg_wide = 0;
    do_read(16'hF00F, 8);
    stream(16'h0F0F, 3);

    // polarity flips and chip select release
    cfg_cs_pol = 1; cfg_dc_pol = 1;
    @(negedge clk);
    chk("R8", "cs active high", bus_cs, 1);
    chk("R8", "dc data state with high-active command", bus_dc, 0);
    do_cmd(17'h0_0011, "R6", 5, 0);
    chk("R8", "command drives DC high", bus_dc, 1);
    set_cs(1);
    chk("R9", "cs released", bus_cs, 0);

    // requests while busy are dropped
    cfg_mode = 0; cfg_wide = 1; cfg_wdiv = 1; cfg_wlo = 2; cfg_whi = 2;
    do_cmd(17'h1_2222, "R11", 12, 1);
    chk("R11", "dc kept after dropped command", bus_dc, 0);
    @(negedge clk);
    chk("R11", "idle after dropped requests", busy, 0);

    // priority
    @(negedge clk); cmd_wr = 1; cmd_word = 17'h0_0077; rd_req = 1; data_valid = 1; data_in = 16'h9999;
    @(negedge clk); cmd_wr = 0; rd_req = 0; data_valid = 0;
    chk("R11", "command wins over read", bus_oe, 1);
    while (busy) @(negedge clk);
    @(negedge clk); rd_req = 1; data_valid = 1; bus_din = 16'h4242; cfg_rdiv = 0;
    @(negedge clk); rd_req = 0; data_valid = 0;
    chk("R11", "read wins over stream", bus_oe, 0);
    while (busy) @(negedge clk);
    chk("R10", "priority read value", rd_data, 16'h4242);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule